// File: doc/BRIEF.md
# Byte-Wide EEPROM Page-Write Controller

This block is a clock-synchronous model of the control logic inside a byte-wide parallel EEPROM. It watches an asynchronous strobe bus made of chip enable, output enable and write enable, all active low. Each strobe passes through a synchroniser chain before any edge is detected. From the strobes the block decodes read cycles and write cycles. Write cycles are byte loads into a page buffer. They stay open for as long as each new load begins within an inactivity window. When the window lapses, a timed internal programming cycle copies the loaded bytes into a register array.

While programming runs, a read returns a status byte instead of stored data. Bit 7 carries the inverted top bit of the last loaded byte. Bit 6 flips on every status read. Bits 5..0 read zero. A host polls either bit to learn when programming has finished. All time constants are parameters counted in clock cycles, so a simulation can use short values.

The bus carries no valid/ready pairing, because the strobes are asynchronous and the block cannot push back on them. The host must hold each strobe level, and the address and data, stable for at least SYNC_STAGES + 2 clock cycles around every strobe edge. A bus cycle that arrives while the block is busy is dropped; it is not stalled.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset, bus_dout_en is 0, bus_dout is 0x00, and every array byte reads 0x00.
- R2: bus_dout_en is high only while the synchronised chip enable and output enable are both low. It follows them with SYNC_STAGES + 1 cycles of latency. bus_dout is 0x00 whenever bus_dout_en is low. Outside programming, a read returns the array byte at the address present when the read began.
- R3: A byte load needs chip enable low, write enable low and output enable high, all together. The address is taken when that overlap begins, which is the later of the two enable falls. The data is taken when the overlap ends, which is the earlier of the two rises. Both write-enable-controlled and chip-enable-controlled cycles work. A write-enable pulse while chip enable is high has no effect.
- R4: The page number is bus_addr[ADDR_W-1:7] and the byte offset is bus_addr[6:0], with 128 bytes per page. The first load of a window fixes the page. A later load to a different page is dropped: it stores nothing and does not restart the window.
- R5: Each accepted load restarts an inactivity counter. Programming begins once WIN_CYC cycles have passed since the last accepted load began and no write is in progress. A window may hold any number of loads. When an offset is loaded twice, the later byte wins.
- R6: Programming lasts PROG_CYC cycles. Afterwards, every loaded byte reads back from the array, and the unloaded bytes of that page keep their old values.
- R7: A byte load that arrives during programming is dropped and does not open a new window.
- R8: During programming, bit 7 of a read is the inverse of bit 7 of the last loaded byte.
- R9: During programming, bit 6 reads 1 on the first read of that programming cycle and inverts on every later read.
- R10: During programming, bits 5..0 of a read are 0.
- R11: A read during an open load window returns the array content, not the buffered bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-assert reset, active low |
| bus_ce_n | input | 1 | Chip enable, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low, asynchronous |
| bus_we_n | input | 1 | Write enable, active low, asynchronous |
| bus_addr | input | ADDR_W | Byte address |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data or status byte, 0 when not driven |
| bus_dout_en | output | 1 | High while the block drives the data bus |

## Verification
A wrong page register or a missing mask bit stays hidden until the programming cycle ends. It shows up only on the array read-back that follows, about WIN_CYC + PROG_CYC cycles after the last load. A stuck state machine shows sooner: the first status read after the window lapses returns stored data instead of a byte with bit 6 set. A toggle register that is not cleared at each programming start appears as a wrong bit 6 on the first status read of the second programming cycle. A bad poll bit appears within one read.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_FILL = 2'd1,
    LD_PROG = 2'd2
  } ld_state_e;
endpackage

// File: rtl/epc_bus_sync.sv
module epc_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_start,
  output logic wr_end,
  output logic wr_act,
  output logic rd_start,
  output logic rd_act
);
  localparam int unsigned LINES = 3;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] line_s;
  assign raw = {we_n, oe_n, ce_n};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], raw[g]};
      end
      assign line_s[g] = sh_q[STAGES-1];
    end
  endgenerate

  logic ce_s, oe_s, we_s;
  assign ce_s = line_s[0];
  assign oe_s = line_s[1];
  assign we_s = line_s[2];

  logic wr_now, rd_now, wr_q, rd_q;
  assign wr_now = !ce_s && !we_s && oe_s;
  assign rd_now = !ce_s && !oe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_now;
      rd_q <= rd_now;
    end
  end

  // overlap start = last enable falling; overlap end = first enable rising
  assign wr_start = wr_now && !wr_q;
  assign wr_end   = !wr_now && wr_q;
  assign wr_act   = wr_now;
  assign rd_start = rd_now && !rd_q;
  assign rd_act   = rd_now;
endmodule

// File: rtl/epc_page_loader.sv
module epc_page_loader
  import epc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned OFF_W    = 7,
  parameter int unsigned WIN_CYC  = 10000,
  parameter int unsigned PROG_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic              prog_busy,
  output logic              prog_start,
  output logic              poll_src,
  output logic              commit_we,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [BYTE_W-1:0] commit_data
);
  localparam int unsigned PAGE_BYTES = 1 << OFF_W;
  localparam int unsigned PG_W       = ADDR_W - OFF_W;
  localparam int unsigned WIN_W      = $clog2(WIN_CYC + 1);
  localparam int unsigned PROG_W     = $clog2(PROG_CYC + 1);

  ld_state_e              state_q;
  logic [PG_W-1:0]        page_q;
  logic [OFF_W-1:0]       off_q;
  logic                   take_q;
  logic [PAGE_BYTES-1:0]  mask_q;
  logic [WIN_W-1:0]       win_q;
  logic [PROG_W-1:0]      prog_q;
  logic                   last_msb_q;
  logic [BYTE_W-1:0]      buf_q [PAGE_BYTES];

  logic [PG_W-1:0]  in_page;
  logic [OFF_W-1:0] in_off;
  logic             accept, expire, prog_done;
  logic [OFF_W-1:0] scan_off;

  assign in_page = addr[ADDR_W-1:OFF_W];
  assign in_off  = addr[OFF_W-1:0];

  assign accept = wr_start &&
                  ((state_q == LD_IDLE) ||
                   ((state_q == LD_FILL) && (in_page == page_q)));
  assign expire = (state_q == LD_FILL) && (win_q == WIN_W'(WIN_CYC - 1)) &&
                  !wr_act && !take_q;
  assign prog_done = (state_q == LD_PROG) && (prog_q == PROG_W'(PROG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LD_IDLE;
      page_q     <= '0;
      off_q      <= '0;
      take_q     <= 1'b0;
      mask_q     <= '0;
      win_q      <= '0;
      prog_q     <= '0;
      last_msb_q <= 1'b0;
    end else begin
      case (state_q)
        LD_IDLE: begin
          if (accept) begin
            state_q <= LD_FILL;
            page_q  <= in_page;
            off_q   <= in_off;
            take_q  <= 1'b1;
            win_q   <= '0;
          end
        end
        LD_FILL: begin
          if (accept) begin
            off_q  <= in_off;
            take_q <= 1'b1;
            win_q  <= '0;
          end else if (win_q != WIN_W'(WIN_CYC - 1)) begin
            win_q <= win_q + 1'b1;
          end
          if (wr_end && take_q) begin
            mask_q[off_q] <= 1'b1;
            last_msb_q    <= din[POLL_BIT];
            take_q        <= 1'b0;
          end
          if (expire) begin
            state_q <= LD_PROG;
            prog_q  <= '0;
          end
        end
        LD_PROG: begin
          if (prog_done) begin
            state_q <= LD_IDLE;
            mask_q  <= '0;
          end else begin
            prog_q <= prog_q + 1'b1;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take_q && wr_end) buf_q[off_q] <= din;
  end

  // commit one buffered byte per cycle during the first PAGE_BYTES cycles
  assign scan_off    = prog_q[OFF_W-1:0];
  assign commit_we   = (state_q == LD_PROG) && (prog_q < PROG_W'(PAGE_BYTES)) &&
                       mask_q[scan_off];
  assign commit_addr = {page_q, scan_off};
  assign commit_data = buf_q[scan_off];

  assign prog_busy  = (state_q == LD_PROG);
  assign prog_start = expire;
  assign poll_src   = last_msb_q;

  a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LD_FILL) && $past(state_q == LD_FILL)) |-> (page_q == $past(page_q)));

  a_r7_no_load_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> !take_q);

  a_r5_start_on_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !wr_act);

  a_r6_prog_enters: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> prog_busy);

  a_r6_prog_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_busy) |-> ($past(prog_q) == PROG_W'(PROG_CYC - 1)));
endmodule

// File: rtl/epc_array.sv
module epc_array
  import epc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/epc_status.sv
module epc_status
  import epc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              rd_act,
  input  logic              prog_busy,
  input  logic              prog_start,
  input  logic              poll_src,
  input  logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en
);
  logic              tgl_q;
  logic              en_q;
  logic [BYTE_W-1:0] dout_q;
  logic [BYTE_W-1:0] stat_byte;

  always_comb begin
    stat_byte             = '0;
    stat_byte[POLL_BIT]   = !poll_src;
    stat_byte[TOGGLE_BIT] = !tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q  <= 1'b0;
      en_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      en_q <= rd_act;
      if (prog_start)                   tgl_q <= 1'b0;
      else if (rd_start && prog_busy)   tgl_q <= !tgl_q;
      if (rd_start) dout_q <= prog_busy ? stat_byte : rdata;
    end
  end

  assign dout    = en_q ? dout_q : '0;
  assign dout_en = en_q;

  a_r2_enable_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> !dout_en);

  a_r8_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && prog_busy) |=> (dout_q[POLL_BIT] != poll_src));
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned PAGE_OFF_W  = 7,
  parameter int unsigned WIN_CYC     = 10000,
  parameter int unsigned PROG_CYC    = 500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_ce_n,
  input  logic                       bus_oe_n,
  input  logic                       bus_we_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [epc_pkg::BYTE_W-1:0] bus_din,
  output logic [epc_pkg::BYTE_W-1:0] bus_dout,
  output logic                       bus_dout_en
);
  localparam int unsigned BW = epc_pkg::BYTE_W;

  logic wr_start, wr_end, wr_act, rd_start, rd_act;
  logic prog_busy, prog_start, poll_src, commit_we;
  logic [ADDR_W-1:0] commit_addr;
  logic [BW-1:0]     commit_data, arr_rdata;

  epc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (bus_ce_n),
    .oe_n     (bus_oe_n),
    .we_n     (bus_we_n),
    .wr_start (wr_start),
    .wr_end   (wr_end),
    .wr_act   (wr_act),
    .rd_start (rd_start),
    .rd_act   (rd_act)
  );

  epc_page_loader #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (PAGE_OFF_W),
    .WIN_CYC  (WIN_CYC),
    .PROG_CYC (PROG_CYC)
  ) u_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_start    (wr_start),
    .wr_end      (wr_end),
    .wr_act      (wr_act),
    .addr        (bus_addr),
    .din         (bus_din),
    .prog_busy   (prog_busy),
    .prog_start  (prog_start),
    .poll_src    (poll_src),
    .commit_we   (commit_we),
    .commit_addr (commit_addr),
    .commit_data (commit_data)
  );

  epc_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit_we),
    .waddr (commit_addr),
    .wdata (commit_data),
    .raddr (bus_addr),
    .rdata (arr_rdata)
  );

  epc_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_start   (rd_start),
    .rd_act     (rd_act),
    .prog_busy  (prog_busy),
    .prog_start (prog_start),
    .poll_src   (poll_src),
    .rdata      (arr_rdata),
    .dout       (bus_dout),
    .dout_en    (bus_dout_en)
  );

  initial begin
    a_r6_prog_covers_page: assert (PROG_CYC > (1 << PAGE_OFF_W));
  end
endmodule

// File: tb/eeprom_page_ctrl_tb_top.sv
module eeprom_page_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 10;
  localparam int WIN  = 60;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = !clk;

  eeprom_page_ctrl #(
    .ADDR_W(AW), .PAGE_OFF_W(7), .WIN_CYC(WIN), .PROG_CYC(PROG), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_dout_en(dout_en)
  );

  function automatic logic [7:0] long_byte(int i);
    logic [7:0] v;
    v = i[7:0];
    return v ^ 8'hC3;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // write-enable-controlled load
  task automatic wr_we(logic [AW-1:0] a, logic [7:0] d);
    addr = a; din = d; oe_n = 1'b1;
    ce_n = 1'b0; repeat (4) @(posedge clk);
    we_n = 1'b0; repeat (5) @(posedge clk);
    we_n = 1'b1; repeat (4) @(posedge clk);
    ce_n = 1'b1; repeat (3) @(posedge clk);
  endtask

  // chip-enable-controlled load
  task automatic wr_ce(logic [AW-1:0] a, logic [7:0] d);
    addr = a; din = d; oe_n = 1'b1;
    we_n = 1'b0; repeat (4) @(posedge clk);
    ce_n = 1'b0; repeat (5) @(posedge clk);
    ce_n = 1'b1; repeat (4) @(posedge clk);
    we_n = 1'b1; repeat (3) @(posedge clk);
  endtask

  // driver: queue the expectation, then run the read cycle
  task automatic rd(logic [AW-1:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a;
    ce_n = 1'b0; oe_n = 1'b0; repeat (6) @(posedge clk);
    oe_n = 1'b1; ce_n = 1'b1; repeat (4) @(posedge clk);
  endtask

  // monitor: compare on each rising edge of the output enable
  logic prev_en = 1'b0;
  always @(negedge clk) begin
    if (rst_n && dout_en && !prev_en) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected drive", dout, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, dout, e);
      end
    end
    prev_en <= dout_en;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 reset dout_en", {7'b0, dout_en}, 8'h00);
    check("R1 reset dout", dout, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    rd(10'h105, 8'h00, "R1 array cleared");

    // R3: write-enable pulse with chip enable high does nothing
    addr = 10'h020; din = 8'h99;
    we_n = 1'b0; repeat (5) @(posedge clk);
    we_n = 1'b1; repeat (WIN + PROG + 50) @(posedge clk);
    rd(10'h020, 8'h00, "R3 no write without CE");

    // page 2 window
    wr_we(10'h100, 8'h3C);
    rd(10'h100, 8'h00, "R11 read during window");
    wr_we(10'h105, 8'hA5);
    wr_we(10'h1C0, 8'h77);          // R4 other page, dropped
    wr_ce(10'h17F, 8'h81);          // R3 CE-controlled
    repeat (WIN + 20) @(posedge clk);
    rd(10'h105, 8'h40, "R8 R9 R10 first status");
    rd(10'h000, 8'h00, "R9 second status");
    rd(10'h105, 8'h40, "R9 third status");
    wr_we(10'h010, 8'h55);          // R7 dropped
    repeat (PROG + WIN + 100) @(posedge clk);
    rd(10'h100, 8'h3C, "R6 WE-controlled byte");
    rd(10'h105, 8'hA5, "R6 second byte");
    rd(10'h17F, 8'h81, "R3 CE-controlled byte");
    rd(10'h1C0, 8'h00, "R4 other page dropped");
    rd(10'h101, 8'h00, "R6 unloaded byte kept");
    rd(10'h010, 8'h00, "R7 write during programming");
    rd(10'h105, 8'hA5, "R7 no new window opened");

    // R5: 130 loads in one window on page 5, offsets 0 and 1 reloaded
    for (int i = 0; i < 130; i++) begin
      logic [6:0] o;
      o = 7'(i % 128);
      wr_we({3'd5, o}, long_byte(i));
    end
    repeat (WIN + 20) @(posedge clk);
    rd(10'h280, 8'hC0, "R8 R9 poll set, toggle restarted");
    rd(10'h280, 8'h80, "R9 toggle inverts");
    repeat (PROG + 50) @(posedge clk);
    rd(10'h280, long_byte(128), "R5 later byte wins offset 0");
    rd(10'h281, long_byte(129), "R5 later byte wins offset 1");
    rd(10'h282, long_byte(2), "R5 offset 2");
    rd(10'h2FF, long_byte(127), "R5 last offset");
    rd(10'h105, 8'hA5, "R6 earlier page intact");

    repeat (5) @(posedge clk);
    check("R2 all reads observed", 8'(exp_q.size()), 8'h00);
    @(negedge clk);
    check("R2 idle bus", dout, 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule